// File: doc/BRIEF.md
# Serial Flash Region Erase Sequencer

This block erases a region of a serial flash on request. A caller presents a start address and a byte length. The block first checks that the region lies on 4 KB sector boundaries and does not run past the top of the address space. It then walks the region from low to high addresses. At each step it uses the largest erase granule that both matches the current alignment and still fits inside the region: 64 KB if possible, then 32 KB, then 4 KB. A separate whole-device erase request issues a single device-erase command instead.

Every erase command is preceded by a write-enable command. After each erase the block reads the status register again and again at a fixed interval until the busy bit clears. It then sends a no-op to end the status stream. While an operation is in progress, the external write-protect release line is driven high with its output enable set. Both go low again on every way out of the operation. The block drives a command-issue interface with an opcode and an address, using a valid/ready handshake, toward an SPI command engine. The block does not serialise anything itself. When the operation ends, a one-cycle done pulse carries a 2-bit result.

Top module: `flash_erase_seq`

## Requirements
- R1: A region request whose start or length has a nonzero value in bits [11:0] completes with a done pulse carrying status 1 one cycle after acceptance. It issues no command, and the write-protect outputs stay low throughout.
- R2: A region request whose start plus length carries out of ADDR_W bits is rejected with status 1 and issues no command.
- R3: Erase steps go from the start upward. A step at address A uses opcode 0xD8 (64 KB) with address A if A[15:0] is zero and A plus 64 KB does not exceed the end. Otherwise it uses 0x52 (32 KB) if A[14:0] is zero and A plus 32 KB fits. Otherwise it uses 0x20 (4 KB).
- R4: Each erase command is immediately preceded by opcode 0x06 (write enable) with address 0. An offered command keeps its opcode and address until it is accepted.
- R5: After each erase the block issues opcode 0x05 and then requests one status read per poll interval, with bit 0 of the result meaning busy. The first non-busy read is followed by opcode 0x00 with address 0, and only then by the next step.
- R6: If MAX_POLLS consecutive status reads all report busy, the block issues opcode 0x00 and ends with status 2. It makes no further erase steps.
- R7: Both write-protect outputs are high from the cycle after an operation starts until the done pulse. Every command is issued while they are high, and they are low when done is asserted.
- R8: A whole-device request issues 0x06, then 0x60 with address 0, then the same poll and 0x00, and ends with status 0 when the poll succeeds.
- R9: A request presented while busy is high is ignored and does not change the command sequence of the operation in progress.
- R10: done is high for exactly one cycle per operation. A region with zero length ends with status 0 and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqChip | input | 1 | 1 = whole-device erase, 0 = region erase |
| reqStart | input | ADDR_W | Region start byte address |
| reqLen | input | ADDR_W | Region length in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 ok, 1 invalid range, 2 timeout |
| wpOut | output | 1 | Write-protect release level |
| wpOe | output | 1 | Output enable for the write-protect line |
| cmdValid | output | 1 | Command offered to the SPI engine |
| cmdReady | input | 1 | SPI engine accepts the command |
| cmdOpcode | output | 8 | Flash opcode |
| cmdAddr | output | ADDR_W | Flash byte address for the command |
| statusReq | output | 1 | One-cycle request for a status-register read |
| statusValid | input | 1 | Status read result is present |
| statusData | input | 8 | Status register value, bit 0 = busy |

## Verification
The bench builds the block with a 20-bit address space, a 2 MHz nominal clock, a 3 µs poll interval and a 60 µs timeout. These values make each poll last six cycles and cut the timeout to 20 busy reads. A timeout therefore finishes in a few hundred cycles. The narrow address space lets a request carry out past the top of memory, which reaches the wrap rejection. With real timings, both cases would take millions of cycles.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER32K = 8'h52;
  localparam logic [7:0] OP_CHIP  = 8'h60;
  localparam logic [7:0] OP_ER64K = 8'hD8;

  localparam int SMALL_SHIFT = 12;
  localparam int MID_SHIFT   = 15;
  localparam int BIG_SHIFT   = 16;

  typedef enum logic [2:0] {
    CS_NONE, CS_WREN, CS_ERASE, CS_CHIP, CS_RDSR, CS_NOP
  } cmdSel_t;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_BAD_RANGE = 2'd1, ST_TIMEOUT = 2'd2
  } result_t;

  typedef struct packed {
    logic    load;
    logic    advance;
    logic    startWait;
    logic    clrPoll;
    logic    incPoll;
    cmdSel_t cmdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/fes_datapath.sv
module fes_datapath
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int POLL_CYCLES = 12500,
  parameter int MAX_POLLS   = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              rangeBad,
  output logic              moreToDo,
  output logic              waitDone,
  output logic              lastPoll,
  output logic              cmdValid,
  output logic [7:0]        cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int WAIT_W = $clog2(POLL_CYCLES + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [ADDR_W:0] BIG_SZ   = (ADDR_W+1)'(1) << BIG_SHIFT;
  localparam logic [ADDR_W:0] MID_SZ   = (ADDR_W+1)'(1) << MID_SHIFT;
  localparam logic [ADDR_W:0] SMALL_SZ = (ADDR_W+1)'(1) << SMALL_SHIFT;

  logic [ADDR_W-1:0] curAddr, endAddr;
  logic [ADDR_W:0]   reqSum, curWide, endWide, stepSize;
  logic [7:0]        eraseOp;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;

  assign reqSum   = {1'b0, reqStart} + {1'b0, reqLen};
  assign rangeBad = (reqStart[SMALL_SHIFT-1:0] != '0) ||
                    (reqLen[SMALL_SHIFT-1:0] != '0) || reqSum[ADDR_W];

  assign curWide  = {1'b0, curAddr};
  assign endWide  = {1'b0, endAddr};
  assign moreToDo = curAddr < endAddr;

  always_comb begin
    if (curAddr[BIG_SHIFT-1:0] == '0 && curWide + BIG_SZ <= endWide) begin
      eraseOp  = OP_ER64K;
      stepSize = BIG_SZ;
    end else if (curAddr[MID_SHIFT-1:0] == '0 && curWide + MID_SZ <= endWide) begin
      eraseOp  = OP_ER32K;
      stepSize = MID_SZ;
    end else begin
      eraseOp  = OP_ER4K;
      stepSize = SMALL_SZ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      endAddr <= '0;
    end else if (strb.load) begin
      curAddr <= reqStart;
      endAddr <= reqSum[ADDR_W-1:0];
    end else if (strb.advance) begin
      curAddr <= curAddr + stepSize[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (strb.startWait)  waitCnt <= WAIT_W'(POLL_CYCLES - 1);
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pollCnt <= '0;
    else if (strb.clrPoll)   pollCnt <= '0;
    else if (strb.incPoll)   pollCnt <= pollCnt + 1'b1;
  end
  assign lastPoll = (pollCnt == POLL_W'(MAX_POLLS - 1));

  always_comb begin
    cmdValid  = (strb.cmdSel != CS_NONE);
    cmdAddr   = '0;
    cmdOpcode = OP_NOP;
    case (strb.cmdSel)
      CS_WREN:  cmdOpcode = OP_WREN;
      CS_ERASE: begin cmdOpcode = eraseOp; cmdAddr = curAddr; end
      CS_CHIP:  cmdOpcode = OP_CHIP;
      CS_RDSR:  cmdOpcode = OP_RDSR;
      default:  cmdOpcode = OP_NOP;
    endcase
  end

endmodule

// File: rtl/fes_control.sv
module fes_control
  import flash_erase_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqChip,
  input  logic        rangeBad,
  input  logic        moreToDo,
  input  logic        waitDone,
  input  logic        lastPoll,
  input  logic        cmdReady,
  input  logic        statusValid,
  input  logic        statusBusy,
  output ctlStrobes_t strb,
  output logic        busy,
  output logic        done,
  output logic [1:0]  doneStatus,
  output logic        wpLevel,
  output logic        statusReq
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_WREN, S_ERASE, S_RDSR, S_WAIT, S_RESP, S_NOP, S_FINISH
  } state_t;

  state_t  state, nextState;
  logic    chipMode;
  result_t outcome, nextOutcome;

  always_comb begin
    nextState   = state;
    nextOutcome = outcome;
    strb        = '0;
    strb.cmdSel = CS_NONE;
    statusReq   = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        strb.load   = 1'b1;
        nextOutcome = ST_OK;
        if (reqChip)        nextState = S_WREN;
        else if (!rangeBad) nextState = S_CHECK;
      end
      S_CHECK: nextState = moreToDo ? S_WREN : S_FINISH;
      S_WREN: begin
        strb.cmdSel = CS_WREN;
        if (cmdReady) nextState = S_ERASE;
      end
      S_ERASE: begin
        strb.cmdSel = chipMode ? CS_CHIP : CS_ERASE;
        if (cmdReady) begin
          strb.advance = !chipMode;
          nextState    = S_RDSR;
        end
      end
      S_RDSR: begin
        strb.cmdSel = CS_RDSR;
        if (cmdReady) begin
          strb.startWait = 1'b1;
          strb.clrPoll   = 1'b1;
          nextState      = S_WAIT;
        end
      end
      S_WAIT: if (waitDone) begin
        statusReq = 1'b1;
        nextState = S_RESP;
      end
      S_RESP: if (statusValid) begin
        if (!statusBusy) begin
          nextState = S_NOP;
        end else if (lastPoll) begin
          nextOutcome = ST_TIMEOUT;
          nextState   = S_NOP;
        end else begin
          strb.incPoll   = 1'b1;
          strb.startWait = 1'b1;
          nextState      = S_WAIT;
        end
      end
      S_NOP: begin
        strb.cmdSel = CS_NOP;
        if (cmdReady)
          nextState = (chipMode || outcome == ST_TIMEOUT) ? S_FINISH : S_CHECK;
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      outcome    <= ST_OK;
      chipMode   <= 1'b0;
      done       <= 1'b0;
      doneStatus <= 2'd0;
      wpLevel    <= 1'b0;
    end else begin
      state   <= nextState;
      outcome <= nextOutcome;
      done    <= 1'b0;
      if (state == S_IDLE && reqValid) begin
        chipMode <= reqChip;
        if (!reqChip && rangeBad) begin
          done       <= 1'b1;
          doneStatus <= ST_BAD_RANGE;
        end else begin
          wpLevel <= 1'b1;
        end
      end
      if (state == S_FINISH) begin
        done       <= 1'b1;
        doneStatus <= outcome;
        wpLevel    <= 1'b0;
      end
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CLK_HZ     = 125000000,
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 200000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqChip,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              busy,
  output logic              done,
  output logic [1:0]        doneStatus,
  output logic              wpOut,
  output logic              wpOe,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [7:0]        cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              statusReq,
  input  logic              statusValid,
  input  logic [7:0]        statusData
);

  localparam int POLL_RAW    = (CLK_HZ / 1000000) * POLL_US;
  localparam int POLL_CYCLES = (POLL_RAW < 1) ? 1 : POLL_RAW;
  localparam int POLLS_RAW   = TIMEOUT_US / POLL_US;
  localparam int MAX_POLLS   = (POLLS_RAW < 1) ? 1 : POLLS_RAW;

  ctlStrobes_t strb;
  logic rangeBad, moreToDo, waitDone, lastPoll, wpLevel;

  fes_datapath #(
    .ADDR_W(ADDR_W), .POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqStart(reqStart), .reqLen(reqLen),
    .rangeBad(rangeBad), .moreToDo(moreToDo),
    .waitDone(waitDone), .lastPoll(lastPoll),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr)
  );

  fes_control u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqChip(reqChip),
    .rangeBad(rangeBad), .moreToDo(moreToDo),
    .waitDone(waitDone), .lastPoll(lastPoll),
    .cmdReady(cmdReady), .statusValid(statusValid),
    .statusBusy(statusData[0]),
    .strb(strb), .busy(busy), .done(done), .doneStatus(doneStatus),
    .wpLevel(wpLevel), .statusReq(statusReq)
  );

  assign wpOut = wpLevel;
  assign wpOe  = wpLevel;

endmodule

// File: rtl/flash_erase_seq_checker.sv
module flash_erase_seq_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [1:0]        doneStatus,
  input logic              wpOut,
  input logic              wpOe,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [7:0]        cmdOpcode,
  input logic [ADDR_W-1:0] cmdAddr
);

  a_r7_cmd_needs_wp: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (wpOut && wpOe));

  a_r7_wp_low_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!wpOut && !wpOe));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (doneStatus != 2'd3));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid);

  a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOpcode) && $stable(cmdAddr)));

endmodule

bind flash_erase_seq flash_erase_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .doneStatus(doneStatus),
  .wpOut(wpOut), .wpOe(wpOe), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;

  localparam int AW = 20;
  localparam int MAX_POLLS = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqChip = 1'b0;
  logic [AW-1:0] reqStart = '0, reqLen = '0;
  logic busy, done, wpOut, wpOe, cmdValid, statusReq;
  logic [1:0] doneStatus;
  logic [7:0] cmdOpcode;
  logic [AW-1:0] cmdAddr;
  logic cmdReady = 1'b0;
  logic statusValid = 1'b0;
  logic [7:0] statusData = '0;

  int compared = 0, mismatched = 0;
  int busyReload = 0, busyLeft = 0, readyCnt = 0, statusReads = 0;
  bit finished = 0;
  logic [31:0] expQ[$];

  always #4 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .CLK_HZ(2000000), .POLL_US(3), .TIMEOUT_US(60))
  i_flash_erase_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChip(reqChip),
    .reqStart(reqStart), .reqLen(reqLen), .busy(busy), .done(done),
    .doneStatus(doneStatus), .wpOut(wpOut), .wpOe(wpOe),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOpcode(cmdOpcode),
    .cmdAddr(cmdAddr), .statusReq(statusReq), .statusValid(statusValid),
    .statusData(statusData)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // SPI engine model: stalls every third cycle, answers status reads one cycle later
  always @(posedge clk) begin
    readyCnt <= readyCnt + 1;
    cmdReady <= (readyCnt % 3) != 0;
    statusValid <= statusReq;
    statusData  <= {7'b0, busyLeft != 0};
    if (cmdValid && cmdReady && cmdOpcode == 8'h05) busyLeft <= busyReload;
    else if (statusReq && busyLeft > 0) busyLeft <= busyLeft - 1;
  end

  // Monitor: pops the scoreboard on every accepted command
  always @(negedge clk) begin
    if (rstN && statusReq) statusReads <= statusReads + 1;
    if (rstN && cmdValid && cmdReady) begin
      logic [31:0] act;
      act = {cmdOpcode, 4'b0, cmdAddr};
      check(wpOut && wpOe, "R7 wp during command", {30'b0, wpOut, wpOe}, 32'h3);
      if (expQ.size() == 0) begin
        check(0, "R4 unexpected command", act, 32'hFFFFFFFF);
      end else begin
        logic [31:0] exp;
        string tag;
        exp = expQ.pop_front();
        case (exp[31:24])
          8'h06:                tag = "R4 write enable";
          8'hD8, 8'h52, 8'h20:  tag = "R3 erase pick";
          8'h60:                tag = "R8 device erase";
          default:              tag = "R5 poll framing";
        endcase
        check(act == exp, tag, act, exp);
      end
    end
  end

  task automatic push(logic [7:0] op, logic [AW-1:0] a);
    expQ.push_back({op, 4'b0, a});
  endtask

  // Expected commands for a region, from the greedy rule of R3
  task automatic expectRegion(int start, int len, bit onlyFirst);
    int a = start;
    int e = start + len;
    while (a < e) begin
      push(8'h06, '0);
      if (a % 65536 == 0 && a + 65536 <= e) begin push(8'hD8, AW'(a)); a += 65536; end
      else if (a % 32768 == 0 && a + 32768 <= e) begin push(8'h52, AW'(a)); a += 32768; end
      else begin push(8'h20, AW'(a)); a += 4096; end
      push(8'h05, '0);
      push(8'h00, '0);
      if (onlyFirst) break;
    end
  endtask

  task automatic runOp(bit chip, int start, int len, int busyN, logic [1:0] expStatus,
                       string req, bit inject);
    int reads0;
    int cyc = 0;
    bit wpBad = 0;
    busyReload = busyN;
    reads0 = statusReads;
    @(negedge clk);
    reqChip = chip; reqStart = AW'(start); reqLen = AW'(len); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (inject) begin
      repeat (8) @(negedge clk);
      check(busy, "R9 busy while running", {31'b0, busy}, 1);
      reqChip = 1'b0; reqStart = AW'(32'h40000); reqLen = AW'(32'h1000); reqValid = 1'b1;
      @(negedge clk);
      reqChip = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done && cyc < 20000) begin
      if (expStatus == 2'd1 && (wpOut || wpOe)) wpBad = 1;
      @(negedge clk);
      cyc++;
    end
    check(done, {req, " done seen"}, {31'b0, done}, 1);
    check(doneStatus == expStatus, {req, " status"}, {30'b0, doneStatus}, {30'b0, expStatus});
    check(!wpOut && !wpOe, "R7 wp low at done", {30'b0, wpOut, wpOe}, 0);
    if (expStatus == 2'd1) check(!wpBad, "R1 wp stays low on reject", {31'b0, wpBad}, 0);
    @(negedge clk);
    check(!done, "R10 done single cycle", {31'b0, done}, 0);
    check(expQ.size() == 0, {req, " all commands seen"}, expQ.size(), 0);
    if (busyN > 0 && expStatus == 2'd2)
      check(statusReads - reads0 == MAX_POLLS, "R6 busy reads before timeout",
            statusReads - reads0, MAX_POLLS);
    expQ.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    check(!done && !busy && !cmdValid && !wpOut && !wpOe, "R10 reset state",
          {27'b0, done, busy, cmdValid, wpOut, wpOe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 64K then three 4K steps, two busy reads per erase
    r0 = statusReads;
    expectRegion(32'h0, 32'h13000, 0);
    runOp(0, 32'h0, 32'h13000, 2, 2'd0, "R3 mixed 64K/4K", 0);
    check(statusReads - r0 == 12, "R5 status reads until idle", statusReads - r0, 12);

    // R3 32K then two 64K, with a stray request while busy (R9)
    expectRegion(32'h8000, 32'h28000, 0);
    runOp(0, 32'h8000, 32'h28000, 1, 2'd0, "R9 ignored request", 1);

    // R3 4K steps up to 32K alignment then 32K
    expectRegion(32'h5000, 32'hB000, 0);
    runOp(0, 32'h5000, 32'hB000, 0, 2'd0, "R3 small then 32K", 0);

    runOp(0, 32'h1800, 32'h1000, 0, 2'd1, "R1 misaligned start", 0);
    runOp(0, 32'h2000, 32'h0800, 0, 2'd1, "R1 misaligned length", 0);
    runOp(0, 32'hF0000, 32'h20000, 0, 2'd1, "R2 wrapping region", 0);
    runOp(0, 32'h40000, 32'h0, 0, 2'd0, "R10 zero length", 0);

    push(8'h06, '0); push(8'h60, '0); push(8'h05, '0); push(8'h00, '0);
    runOp(1, 32'h0, 32'h0, 3, 2'd0, "R8 device erase", 0);

    expectRegion(32'h10000, 32'h20000, 1);
    runOp(0, 32'h10000, 32'h20000, 1000, 2'd2, "R6 timeout", 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule